// File: doc/BRIEF.md
# Break Control Register with Staged Write Protection

This block is a 32-bit control register that sets up the break and dead-time functions of a power-stage timer. Software writes it through a simple one-cycle write port. The block sends the decoded configuration fields to the filter and dead-time logic next to it. It also drives the main output enable and a flag that shows a break is active.

A 2-bit protection level can be set once per reset, and it decides which fields later writes may change. Level 1 freezes the dead-time, filter, enable, polarity, bidirectional and automatic-enable settings. Level 2 also freezes the two off-state selection bits. Level 3 adds nothing beyond level 2 inside this register. The main output enable drops at once, with no clock edge, when an enabled break input reaches its active level. When automatic enabling is selected, the enable is set again on an update event if no break is active.

Top module: `brk_ctrl_reg`

## Requirements
- R1: The protection level at bits [9:8] is loaded only by the first write after reset. Any write at all closes the field, and later writes leave it unchanged until the next reset.
- R2: At protection level 1 or higher, writes leave these fields unchanged: dead time [7:0], automatic enable [13], enable A [14], polarity A [15], filter A [19:16], enable B [20], polarity B [21], filter B [25:22], bidirectional A [26] and bidirectional B [27].
- R3: At protection level 2 or higher, writes also leave the idle off-state bit [10] and the run off-state bit [11] unchanged. At level 1 these two bits can still be written.
- R4: At protection level 0, every field can be written. Bit 12 and bits [29:28] can be written at every level. Bits [31:30] always read as 0.
- R5: `main_oe` (read back at bit 12) goes low in the same cycle that an enabled break input becomes active, without waiting for a clock edge. The stored enable stays cleared after the break goes away.
- R6: With automatic enable [13] set, an update event with no active break sets `main_oe` at the next edge. With [13] clear, update events do not change it.
- R7: Input A is `brk_in[0]` and input B is `brk_in[1]`. An input is active when its enable is 1 and its level equals its polarity bit: polarity 0 means active low and polarity 1 means active high. A disabled input never counts as active.
- R8: A written enable, polarity or bidirectional bit shows on the read-back word after the write edge. It reaches the `brk_en`, `brk_pol` and `brk_bidir` outputs and the break detection one cycle later.
- R9: A disarm bit (A at [28], B at [29]) is loaded by every write. When there is no write, hardware clears it at any edge where its input is not active, and it holds while the input is active.
- R10: While any break is active, a write that sets bit 12 leaves `main_oe` low.
- R11: After reset, the read-back word, every decoded field, `main_oe` and `brk_active` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write value |
| brk_in | input | 2 | Break inputs, [0]=A and [1]=B |
| upd_evt | input | 1 | Update event pulse from the counter |
| cfg_word | output | 32 | Register read-back |
| dead_time | output | 8 | Dead-time code |
| lock_lvl | output | 2 | Current protection level |
| off_idle_sel | output | 1 | Off-state selection while outputs are disabled |
| off_run_sel | output | 1 | Off-state selection while outputs are enabled |
| auto_oe | output | 1 | Automatic re-enable selected |
| brk_en | output | 2 | Effective break enables |
| brk_pol | output | 2 | Effective break polarities |
| brk_filt_a | output | 4 | Filter code for input A |
| brk_filt_b | output | 4 | Filter code for input B |
| brk_bidir | output | 2 | Effective bidirectional mode bits |
| brk_disarm | output | 2 | Disarm flags |
| main_oe | output | 1 | Main output enable |
| brk_active | output | 1 | At least one enabled break is active |

## Verification
A wrong protection level or a wrong closed flag shows on the next write: a frozen field changes in `cfg_word`, or a free one does not. A stale effective enable or polarity makes `brk_active` and `main_oe` disagree with the inputs within one cycle of the input changing. A stuck disarm or main-enable flop shows on `cfg_word` at the first edge where hardware should have cleared or set it. The bench compares every output to its model on every cycle, so any of these errors is found in the cycle where it first becomes visible.

// File: rtl/brkreg_pkg.sv
// Package: field positions, protection levels and write-mask derivation
// for the break control register.
// Assumes a fixed 32-bit layout with two break channels.
package brkreg_pkg;

    localparam int REG_W    = 32;
    localparam int DT_W     = 8;
    localparam int LOCK_W   = 2;
    localparam int FILT_W   = 4;
    localparam int NUM_BRK  = 2;

    localparam int DT_LSB    = 0;
    localparam int LOCK_LSB  = 8;
    localparam int OFFI_BIT  = 10;
    localparam int OFFR_BIT  = 11;
    localparam int MOE_BIT   = 12;
    localparam int AOE_BIT   = 13;
    localparam int FILTA_LSB = 16;
    localparam int FILTB_LSB = 22;
    localparam int DIS_LSB   = 28;

    // Bits owned by hardware or reserved: never taken from the write mask
    localparam logic [REG_W-1:0] HW_BITS   = 32'hF000_1000;
    localparam logic [REG_W-1:0] LOCK_BITS = 32'h0000_0300;
    localparam logic [REG_W-1:0] OFF_BITS  = 32'h0000_0C00;
    localparam logic [REG_W-1:0] L1_BITS   = 32'h0FFF_E0FF;

    typedef enum logic [LOCK_W-1:0] {
        PROT_NONE = 2'd0,
        PROT_L1   = 2'd1,
        PROT_L2   = 2'd2,
        PROT_L3   = 2'd3
    } prot_lvl_e;

    // Per-channel bit positions (channel 0 = A, channel 1 = B)
    function automatic int en_pos(input int ch);
        return (ch == 0) ? 14 : 20;
    endfunction

    function automatic int pol_pos(input int ch);
        return (ch == 0) ? 15 : 21;
    endfunction

    function automatic int bid_pos(input int ch);
        return (ch == 0) ? 26 : 27;
    endfunction

    // Writable ordinary fields for a given protection level
    function automatic logic [REG_W-1:0] field_mask(input prot_lvl_e lvl);
        logic [REG_W-1:0] m;
        m = ~(HW_BITS | LOCK_BITS);
        if (lvl != PROT_NONE) m = m & ~L1_BITS;
        if (lvl == PROT_L2 || lvl == PROT_L3) m = m & ~OFF_BITS;
        return m;
    endfunction

endpackage

// File: rtl/brk_lock_guard.sv
// Protection-level holder.
// Stores the write-once protection level and turns it into a write mask
// for the ordinary fields. Assumes any write closes the level field.
module brk_lock_guard
    import brkreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LOCK_W-1:0] wr_lock,
    output logic [LOCK_W-1:0] lock_lvl,
    output logic [REG_W-1:0]  wr_mask
);

    logic [LOCK_W-1:0] lock_q;
    logic              closed_q;

    // Load the level on the first write only, then close it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= '0;
            closed_q <= 1'b0;
        end else if (wr_en) begin
            if (!closed_q) lock_q <= wr_lock;
            closed_q <= 1'b1;
        end
    end

    // Mask of the fields that the current level still allows
    always_comb begin
        wr_mask = field_mask(prot_lvl_e'(lock_q));
    end

    assign lock_lvl = lock_q;

    AST_LOCK_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        closed_q |=> $stable(lock_q)); // R1

endmodule

// File: rtl/brk_sense.sv
// Break channel sensing.
// Delays the stored enable, polarity and bidirectional bits by one cycle,
// decodes the active level of the raw input (asynchronous path) and keeps
// the disarm flag that hardware clears when the source is not active.
module brk_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic en_st,
    input  logic pol_st,
    input  logic bid_st,
    input  logic dis_wr,
    input  logic dis_wd,
    input  logic raw,
    output logic en_eff,
    output logic pol_eff,
    output logic bid_eff,
    output logic dis_q,
    output logic active
);

    // One-cycle lag before written settings take effect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_eff  <= 1'b0;
            pol_eff <= 1'b0;
            bid_eff <= 1'b0;
        end else begin
            en_eff  <= en_st;
            pol_eff <= pol_st;
            bid_eff <= bid_st;
        end
    end

    // Active level decode: polarity 1 = high active, 0 = low active
    always_comb begin
        active = en_eff && (raw == pol_eff);
    end

    // Disarm flag: written by software, cleared once the source is idle
    always_ff @(posedge clk) begin
        if (!rst_n)       dis_q <= 1'b0;
        else if (dis_wr)  dis_q <= dis_wd;
        else if (!active) dis_q <= 1'b0;
    end

    AST_ENABLE_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_st) |-> !en_eff); // R8
    AST_DISARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && active && !dis_wr) |=> dis_q); // R9
    AST_DISARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !active && !dis_wr) |=> !dis_q); // R9

endmodule

// File: rtl/brk_moe_ctrl.sv
// Main output enable control.
// A break clears the enable combinationally; software may write it; an
// update event sets it when automatic enabling is selected. Assumes
// brk_any is already qualified by the channel enables.
module brk_moe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_any,
    input  logic wr_en,
    input  logic wr_moe,
    input  logic upd_evt,
    input  logic auto_oe,
    output logic main_oe
);

    logic moe_q;

    // Stored enable: break has priority, then software, then auto set
    always_ff @(posedge clk) begin
        if (!rst_n)                   moe_q <= 1'b0;
        else if (brk_any)             moe_q <= 1'b0;
        else if (wr_en)               moe_q <= wr_moe;
        else if (upd_evt && auto_oe)  moe_q <= 1'b1;
    end

    // Output gated by the break without waiting for an edge
    assign main_oe = moe_q && !brk_any;

    AST_AUTO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && auto_oe && !brk_any && !wr_en) |=> moe_q); // R6
    AST_NO_AUTO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_oe && !wr_en && !moe_q) |=> !moe_q); // R6
    AST_SW_SET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_any && wr_en && wr_moe) |=> !moe_q); // R10
    AST_BREAK_LATCHES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_any && !wr_en) |=> !moe_q); // R5

endmodule

// File: rtl/brk_ctrl_reg.sv
// Break control register top.
// Holds the ordinary configuration fields under the write mask from the
// protection guard, instantiates one sensing slice per break channel and
// the main output enable control, and assembles the read-back word.
// Assumes wr_en is a single-cycle strobe in the clk domain.
module brk_ctrl_reg
    import brkreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [NUM_BRK-1:0] brk_in,
    input  logic              upd_evt,
    output logic [REG_W-1:0]  cfg_word,
    output logic [DT_W-1:0]   dead_time,
    output logic [LOCK_W-1:0] lock_lvl,
    output logic              off_idle_sel,
    output logic              off_run_sel,
    output logic              auto_oe,
    output logic [NUM_BRK-1:0] brk_en,
    output logic [NUM_BRK-1:0] brk_pol,
    output logic [FILT_W-1:0] brk_filt_a,
    output logic [FILT_W-1:0] brk_filt_b,
    output logic [NUM_BRK-1:0] brk_bidir,
    output logic [NUM_BRK-1:0] brk_disarm,
    output logic              main_oe,
    output logic              brk_active
);

    logic [REG_W-1:0]   cfg_q;
    logic [REG_W-1:0]   wr_mask;
    logic [NUM_BRK-1:0] act;
    logic               brk_any;

    brk_lock_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_lock  (wr_data[LOCK_LSB +: LOCK_W]),
        .lock_lvl (lock_lvl),
        .wr_mask  (wr_mask)
    );

    // Ordinary fields: only bits allowed by the mask take the write value
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= (cfg_q & ~wr_mask) | (wr_data & wr_mask);
    end

    for (genvar ch = 0; ch < NUM_BRK; ch++) begin : g_chan
        brk_sense u_sense (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_st   (cfg_q[en_pos(ch)]),
            .pol_st  (cfg_q[pol_pos(ch)]),
            .bid_st  (cfg_q[bid_pos(ch)]),
            .dis_wr  (wr_en),
            .dis_wd  (wr_data[DIS_LSB + ch]),
            .raw     (brk_in[ch]),
            .en_eff  (brk_en[ch]),
            .pol_eff (brk_pol[ch]),
            .bid_eff (brk_bidir[ch]),
            .dis_q   (brk_disarm[ch]),
            .active  (act[ch])
        );
    end

    assign brk_any    = |act;
    assign brk_active = brk_any;

    brk_moe_ctrl u_moe (
        .clk     (clk),
        .rst_n   (rst_n),
        .brk_any (brk_any),
        .wr_en   (wr_en),
        .wr_moe  (wr_data[MOE_BIT]),
        .upd_evt (upd_evt),
        .auto_oe (cfg_q[AOE_BIT]),
        .main_oe (main_oe)
    );

    // Decoded configuration fields
    assign dead_time    = cfg_q[DT_LSB +: DT_W];
    assign off_idle_sel = cfg_q[OFFI_BIT];
    assign off_run_sel  = cfg_q[OFFR_BIT];
    assign auto_oe      = cfg_q[AOE_BIT];
    assign brk_filt_a   = cfg_q[FILTA_LSB +: FILT_W];
    assign brk_filt_b   = cfg_q[FILTB_LSB +: FILT_W];

    // Read-back word: stored fields merged with hardware-owned bits
    always_comb begin
        cfg_word = cfg_q & ~(HW_BITS | LOCK_BITS);
        cfg_word[LOCK_LSB +: LOCK_W]  = lock_lvl;
        cfg_word[MOE_BIT]             = main_oe;
        cfg_word[DIS_LSB +: NUM_BRK]  = brk_disarm;
    end

    AST_L1_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl != 2'd0 && wr_en) |=> ($stable(dead_time) && $stable(brk_filt_a)
            && $stable(brk_filt_b) && $stable(auto_oe))); // R2
    AST_L2_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl[1] && wr_en) |=> ($stable(off_idle_sel) && $stable(off_run_sel))); // R3
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[31:30] == 2'b00); // R4

endmodule

// File: tb/brk_ctrl_reg_tb_top.sv
module brk_ctrl_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  brk_in = '0;
    logic        upd_evt = 1'b0;

    logic [31:0] cfg_word;
    logic [7:0]  dead_time;
    logic [1:0]  lock_lvl;
    logic        off_idle_sel, off_run_sel, auto_oe;
    logic [1:0]  brk_en, brk_pol, brk_bidir, brk_disarm;
    logic [3:0]  brk_filt_a, brk_filt_b;
    logic        main_oe, brk_active;

    always #4 clk = ~clk;

    brk_ctrl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .brk_in(brk_in), .upd_evt(upd_evt), .cfg_word(cfg_word),
        .dead_time(dead_time), .lock_lvl(lock_lvl), .off_idle_sel(off_idle_sel),
        .off_run_sel(off_run_sel), .auto_oe(auto_oe), .brk_en(brk_en),
        .brk_pol(brk_pol), .brk_filt_a(brk_filt_a), .brk_filt_b(brk_filt_b),
        .brk_bidir(brk_bidir), .brk_disarm(brk_disarm), .main_oe(main_oe),
        .brk_active(brk_active)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R11";
    bit    chk_on = 0;
    bit    rst_req = 0;

    // Reference model state
    logic [31:0] m_cfg;
    bit          m_done, m_moe;
    logic [1:0]  m_dis, m_en, m_pol, m_bid;

    function automatic logic [1:0] m_act();
        logic [1:0] a;
        for (int ch = 0; ch < 2; ch++) a[ch] = m_en[ch] && (brk_in[ch] == m_pol[ch]);
        return a;
    endfunction

    function automatic bit writable(int b);
        if (b == 12 || b >= 28) return 0;
        if (b == 8 || b == 9)   return !m_done;
        if (b == 10 || b == 11) return m_cfg[9:8] < 2'd2;
        return m_cfg[9:8] == 2'd0;
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [1:0]  a;
        logic        exp_oe;
        logic [31:0] w;
        a = m_act();
        exp_oe = m_moe && !(|a);
        w = m_cfg;
        w[12] = exp_oe;
        w[29:28] = m_dis;
        w[31:30] = 2'b00;
        chk("cfg_word", cfg_word, w);
        chk("main_oe", {31'b0, main_oe}, {31'b0, exp_oe});
        chk("brk_active", {31'b0, brk_active}, {31'b0, |a});
        chk("eff_bits", {26'b0, brk_en, brk_pol, brk_bidir}, {26'b0, m_en, m_pol, m_bid});
        chk("disarm", {30'b0, brk_disarm}, {30'b0, m_dis});
        chk("fields", {dead_time, lock_lvl, off_idle_sel, off_run_sel, auto_oe, brk_filt_a, brk_filt_b},
            {m_cfg[7:0], m_cfg[9:8], m_cfg[10], m_cfg[11], m_cfg[13], m_cfg[19:16], m_cfg[25:22]});
    endtask

    task automatic model_edge();
        logic [1:0]  a;
        logic [31:0] nc;
        if (!rst_n) begin
            m_cfg = '0; m_done = 0; m_moe = 0;
            m_dis = '0; m_en = '0; m_pol = '0; m_bid = '0;
            return;
        end
        a = m_act();
        if (|a)                        m_moe = 0;
        else if (wr_en)                m_moe = wr_data[12];
        else if (upd_evt && m_cfg[13]) m_moe = 1;
        m_dis = wr_en ? wr_data[29:28] : (m_dis & a);
        m_en  = {m_cfg[20], m_cfg[14]};
        m_pol = {m_cfg[21], m_cfg[15]};
        m_bid = {m_cfg[27], m_cfg[26]};
        if (wr_en) begin
            nc = m_cfg;
            for (int b = 0; b < 32; b++) if (writable(b)) nc[b] = wr_data[b];
            m_cfg  = nc;
            m_done = 1;
        end
    endtask

    task automatic cyc(bit w, logic [31:0] wd, logic [1:0] brk, bit up);
        @(negedge clk);
        rst_n = rst_req; wr_en = w; wr_data = wd; brk_in = brk; upd_evt = up;
        #1;
        if (chk_on) compare();
        @(posedge clk);
        model_edge();
    endtask

    task automatic do_reset();
        chk_on = 0;
        rst_req = 0;
        repeat (3) cyc(0, '0, 2'b00, 0);
        rst_req = 1;
        chk_on = 1;
        cur_req = "R11";
        cyc(0, '0, 2'b00, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        cyc(0, '0, 2'b11, 1);

        // R4: level 0, all ordinary fields writable; R1 level closed at 0
        cur_req = "R4";
        cyc(1, 32'h0000_3CA5, 2'b00, 0);
        cyc(1, 32'h0FFF_E35A, 2'b00, 0);
        cur_req = "R1";
        cyc(1, 32'hFFFF_F3FF, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        cur_req = "R4";
        cyc(1, 32'h0000_0000, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);

        // R7/R5/R8: channel A high active
        cur_req = "R8";
        cyc(1, 32'h0000_D000, 2'b01, 0);
        cyc(0, '0, 2'b01, 0);
        cur_req = "R5";
        cyc(0, '0, 2'b00, 0);
        cyc(0, '0, 2'b01, 0);
        cyc(0, '0, 2'b01, 0);
        cyc(0, '0, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        cur_req = "R10";
        cyc(1, 32'h0000_D000, 2'b01, 0);
        cyc(0, '0, 2'b01, 0);
        cyc(0, '0, 2'b00, 0);
        // R7: channel B low active, A disabled
        cur_req = "R7";
        cyc(1, 32'h0010_1000, 2'b11, 0);
        cyc(0, '0, 2'b11, 0);
        cyc(0, '0, 2'b01, 0);
        cyc(0, '0, 2'b00, 0);
        cyc(0, '0, 2'b10, 0);
        cyc(1, 32'h0030_0000, 2'b10, 0);
        cyc(0, '0, 2'b10, 0);
        cyc(0, '0, 2'b00, 0);

        // R6: automatic enable
        cur_req = "R6";
        cyc(1, 32'h0000_2000, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        cyc(0, '0, 2'b00, 1);
        cyc(0, '0, 2'b00, 0);
        cyc(1, 32'h0000_0000, 2'b00, 0);
        cyc(0, '0, 2'b00, 1);
        cyc(0, '0, 2'b00, 0);
        cyc(1, 32'h0000_E000, 2'b01, 0);
        cyc(0, '0, 2'b01, 1);
        cyc(0, '0, 2'b00, 1);
        cyc(0, '0, 2'b00, 0);

        // R9: disarm flags
        cur_req = "R9";
        cyc(1, 32'h1000_C000, 2'b01, 0);
        cyc(0, '0, 2'b01, 0);
        cyc(0, '0, 2'b01, 0);
        cyc(0, '0, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        cyc(1, 32'h3000_0000, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);

        // R5: mixed random traffic at level 0
        cur_req = "R5";
        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 4) == 0, $urandom, 2'($urandom), ($urandom % 3) == 0);
        end

        // R2: level 1
        do_reset();
        cur_req = "R2";
        cyc(1, 32'h0AC5_41A5, 2'b00, 0);
        cyc(1, 32'h0FFF_FCFF, 2'b00, 0);
        cyc(1, 32'h0000_0000, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        cur_req = "R3";
        cyc(1, 32'h0000_0C00, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        cur_req = "R1";
        cyc(1, 32'h0000_0300, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);

        // R3: level 2 and level 3
        do_reset();
        cur_req = "R3";
        cyc(1, 32'h0000_0E33, 2'b00, 0);
        cyc(1, 32'h0000_1000, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        do_reset();
        cyc(1, 32'h0000_0300, 2'b00, 0);
        cyc(1, 32'h0FFF_FCFF, 2'b00, 0);
        cyc(0, '0, 2'b00, 0);
        cur_req = "R2";
        for (int i = 0; i < 100; i++) begin
            cyc(($urandom % 2) == 0, $urandom, 2'($urandom), ($urandom % 3) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule